// File: doc/BRIEF.md
# Two-Dimensional Window DMA Channel

This block is one channel of a DMA engine that moves a rectangular window of memory one line at a time. Software describes a transfer with a descriptor: a start address, a byte count per line, a line count and a stride, which is the distance between the first bytes of two neighbouring lines. The channel turns the descriptor into a series of bus bursts. Each burst carries an address, a byte length and a direction. Every burst is handed over on a request/acknowledge handshake.

The channel holds one running descriptor and one waiting descriptor. The `pend` output tells software that the waiting slot is taken. A descriptor written to an enabled, idle channel starts at once. A waiting descriptor takes over on the clock after the running one ends, so the bus sees no gap. Nothing is reloaded automatically.

Write bursts are at most 64 bytes long. Read bursts have a programmable size. After each read burst, the channel waits until that many bytes have drained from its buffer before it issues the next read.

Top module: `dma2d_chan`

## Requirements
- R1: After reset `bus_req`, `pend`, `busy` and `done` are all 0.
- R2: A descriptor written while `busy` is 0 and `chan_en` is 1 raises `bus_req` one cycle after the write cycle. The first address is the start address.
- R3: While the waiting slot is occupied, `pend` is 1 and a descriptor write is discarded. A discarded descriptor never produces a burst.
- R4: A burst stays requested with a stable address and length until `bus_ack`. Within a line the address steps by the burst length. Line n begins at start plus n times stride.
- R5: The last burst of a line carries only the bytes that remain in that line.
- R6: Write bursts (`cfg_is_read` = 0) are 64 bytes long, except for a shortened last burst of a line.
- R7: The read burst length is selected by `rd_size`: code 0 gives 64 bytes, code 1 gives 128 bytes, and codes 2 and 3 give 256 bytes.
- R8: The first read burst after reset is not held back. After each acknowledged read burst, no read is requested until the bytes reported on `buf_drain` add up to at least the read burst length.
- R9: `done` is high for exactly the acknowledge cycle of the last burst of the last line.
- R10: A waiting descriptor becomes active on the clock edge that ends the running one. `pend` falls on that same edge, and its first burst is requested in the very next cycle.
- R11: Once the running and waiting descriptors have both finished, `busy` and `bus_req` stay 0 until a new descriptor is written.
- R12: A descriptor with zero bytes per line or zero lines raises `done` in the cycle after the write and issues no burst.
- R13: While `chan_en` is 0, a written descriptor is held (`busy` = 1) but no burst is requested. Raising `chan_en` lets the request appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enabled; bursts and completion only advance while 1 |
| rd_size | input | 2 | Read burst size code (0: 64, 1: 128, 2 or 3: 256 bytes) |
| cfg_wr | input | 1 | Descriptor write strobe |
| cfg_start | input | 32 | Window start address |
| cfg_bytes | input | 16 | Bytes per line |
| cfg_lines | input | 12 | Number of lines |
| cfg_stride | input | 32 | Address distance from one line start to the next |
| cfg_is_read | input | 1 | 1: the descriptor reads memory, 0: it writes memory |
| pend | output | 1 | Waiting slot occupied; further writes are discarded |
| busy | output | 1 | A descriptor is active |
| done | output | 1 | One-cycle pulse when a descriptor completes |
| bus_req | output | 1 | Burst request |
| bus_write | output | 1 | Burst direction, 1 for a memory write |
| bus_addr | output | 32 | Burst start address |
| bus_len | output | 9 | Burst length in bytes |
| bus_ack | input | 1 | Burst accepted |
| buf_drain | input | 9 | Bytes that left the channel buffer this cycle |

## Verification
The bench builds the channel with the package defaults: 32-bit addresses, 16-bit byte counts, 12-bit line counts and a 9-bit length field. With these widths the 256-byte read code can be reached, so a read burst can cover the full length field. The same widths allow strides of kilobytes, which makes line bases stand apart from in-line steps in the address checks. Line lengths of 100 and 300 bytes are not multiples of any burst size, so both write and read runs end every line on a shortened burst.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    localparam int ADDR_W   = 32;
    localparam int CNT_W    = 16;
    localparam int LINE_W   = 12;
    localparam int LEN_W    = 9;
    localparam int WR_BURST = 64;
    localparam int ACC_W    = LEN_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  bytes;
        logic [LINE_W-1:0] lines;
        logic [ADDR_W-1:0] stride;
        logic              is_read;
    } shape_t;

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        shape_t            shape;
    } desc_t;

    function automatic logic [LEN_W-1:0] rd_burst_len(input logic [1:0] code);
        case (code)
            2'd0:    return LEN_W'(64);
            2'd1:    return LEN_W'(128);
            default: return LEN_W'(256);
        endcase
    endfunction
endpackage

// File: rtl/dma2d_slots.sv
module dma2d_slots
    import dma2d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  desc_t             wr_desc,
    input  logic              finish,
    output logic              act_valid,
    output shape_t            act_shape,
    output logic              que_valid,
    output logic              load,
    output logic [ADDR_W-1:0] ld_start
);
    typedef struct packed {
        logic  act_v;
        desc_t act;
        logic  que_v;
        desc_t que;
    } st_t;

    st_t  st_d, st_q;
    logic accept;

    always_comb begin
        st_d     = st_q;
        accept   = wr && !st_q.que_v;
        load     = 1'b0;
        ld_start = wr_desc.start;
        if (finish) begin
            if (st_q.que_v) begin
                st_d.act   = st_q.que;
                st_d.que_v = 1'b0;
                load       = 1'b1;
                ld_start   = st_q.que.start;
            end else if (accept) begin
                st_d.act = wr_desc;
                load     = 1'b1;
            end else begin
                st_d.act_v = 1'b0;
            end
        end else if (accept) begin
            if (!st_q.act_v) begin
                st_d.act   = wr_desc;
                st_d.act_v = 1'b1;
                load       = 1'b1;
            end else begin
                st_d.que   = wr_desc;
                st_d.que_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_valid = st_q.act_v;
    assign act_shape = st_q.act.shape;
    assign que_valid = st_q.que_v;

    p_pend_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.que_v && wr && !finish |=> st_q.que_v && $stable(st_q.que));

    p_finish_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> st_q.act_v);
endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk
    import dma2d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_start,
    input  shape_t            shp,
    input  logic [LEN_W-1:0]  rd_len,
    input  logic              gate_ok,
    input  logic              ack,
    output logic              req,
    output logic              write,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  len,
    output logic              finish
);
    typedef struct packed {
        logic              run;
        logic [LINE_W-1:0] line;
        logic [CNT_W-1:0]  off;
        logic [ADDR_W-1:0] base;
    } st_t;

    st_t              st_d, st_q;
    logic [LEN_W-1:0] burst;
    logic [CNT_W-1:0] rem, end_off;
    logic             zero, line_end, last, fire;

    always_comb begin
        burst    = shp.is_read ? rd_len : LEN_W'(WR_BURST);
        rem      = shp.bytes - st_q.off;
        len      = (rem < CNT_W'(burst)) ? rem[LEN_W-1:0] : burst;
        end_off  = st_q.off + CNT_W'(len);
        line_end = (end_off == shp.bytes);
        last     = line_end && (st_q.line == shp.lines - 1'b1);
        zero     = (shp.bytes == '0) || (shp.lines == '0);
        req      = st_q.run && en && !zero && (!shp.is_read || gate_ok);
        fire     = req && ack;
        finish   = st_q.run && en && (zero || (fire && last));
        addr     = st_q.base + ADDR_W'(st_q.off);
        write    = !shp.is_read;

        st_d = st_q;
        if (fire) begin
            if (line_end) begin
                st_d.off  = '0;
                st_d.line = st_q.line + 1'b1;
                st_d.base = st_q.base + shp.stride;
            end else begin
                st_d.off = end_off;
            end
        end
        if (finish) st_d.run = 1'b0;
        if (load) begin
            st_d.run  = 1'b1;
            st_d.off  = '0;
            st_d.line = '0;
            st_d.base = ld_start;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack |=> (req || !en) && $stable(addr) && $stable(len));

    p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> len != '0);

    p_wr_burst_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req && write |-> len <= LEN_W'(WR_BURST));
endmodule

// File: rtl/dma2d_rd_gate.sv
module dma2d_rd_gate
    import dma2d_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rd_size,
    input  logic [LEN_W-1:0] drain,
    input  logic             rd_fire,
    output logic [LEN_W-1:0] burst_len,
    output logic             ok
);
    typedef struct packed {
        logic             armed;
        logic [ACC_W-1:0] drained;
    } st_t;

    st_t            st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        burst_len = rd_burst_len(rd_size);
        ok        = !st_q.armed || (st_q.drained >= ACC_W'(burst_len));
        sum       = {1'b0, st_q.drained} + (ACC_W + 1)'(drain);
        st_d      = st_q;
        if (rd_fire) begin
            st_d.armed   = 1'b1;
            st_d.drained = ACC_W'(drain);
        end else begin
            st_d.drained = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_gate_shut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire && drain == '0 |=> !ok);
endmodule

// File: rtl/dma2d_chan.sv
module dma2d_chan
    import dma2d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [1:0]        rd_size,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [CNT_W-1:0]  cfg_bytes,
    input  logic [LINE_W-1:0] cfg_lines,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic              cfg_is_read,
    output logic              pend,
    output logic              busy,
    output logic              done,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LEN_W-1:0]  bus_len,
    input  logic              bus_ack,
    input  logic [LEN_W-1:0]  buf_drain
);
    desc_t             wr_desc;
    shape_t            act_shape;
    logic              load, finish, gate_ok, rd_fire;
    logic [ADDR_W-1:0] ld_start;
    logic [LEN_W-1:0]  rd_len;

    always_comb begin
        wr_desc.start         = cfg_start;
        wr_desc.shape.bytes   = cfg_bytes;
        wr_desc.shape.lines   = cfg_lines;
        wr_desc.shape.stride  = cfg_stride;
        wr_desc.shape.is_read = cfg_is_read;
    end

    dma2d_slots u_slots (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_desc(wr_desc), .finish(finish),
        .act_valid(busy), .act_shape(act_shape), .que_valid(pend),
        .load(load), .ld_start(ld_start)
    );

    dma2d_rd_gate u_gate (
        .clk(clk), .rst_n(rst_n), .rd_size(rd_size), .drain(buf_drain),
        .rd_fire(rd_fire), .burst_len(rd_len), .ok(gate_ok)
    );

    dma2d_walk u_walk (
        .clk(clk), .rst_n(rst_n), .en(chan_en), .load(load), .ld_start(ld_start),
        .shp(act_shape), .rd_len(rd_len), .gate_ok(gate_ok), .ack(bus_ack),
        .req(bus_req), .write(bus_write), .addr(bus_addr), .len(bus_len),
        .finish(finish)
    );

    assign rd_fire = bus_req && bus_ack && !bus_write;
    assign done    = finish;

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req && !done);

    p_pend_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> busy);
endmodule

// File: tb/dma2d_chan_tb.sv
module dma2d_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b1;
    logic [1:0]  rd_size = 2'd0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_start = '0;
    logic [15:0] cfg_bytes = '0;
    logic [11:0] cfg_lines = '0;
    logic [31:0] cfg_stride = '0;
    logic        cfg_is_read = 1'b0;
    logic        pend, busy, done, bus_req, bus_write;
    logic [31:0] bus_addr;
    logic [8:0]  bus_len;
    logic        bus_ack = 1'b0;
    logic [8:0]  buf_drain = '0;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit dn;

    always #4 clk = ~clk;

    dma2d_chan u_dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rd_size(rd_size),
        .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_bytes(cfg_bytes),
        .cfg_lines(cfg_lines), .cfg_stride(cfg_stride), .cfg_is_read(cfg_is_read),
        .pend(pend), .busy(busy), .done(done), .bus_req(bus_req),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_len(bus_len),
        .bus_ack(bus_ack), .buf_drain(buf_drain)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr_desc(input logic [31:0] s, input logic [15:0] b, input logic [11:0] l,
                           input logic [31:0] st, input logic rd);
        @(negedge clk);
        cfg_start = s; cfg_bytes = b; cfg_lines = l; cfg_stride = st; cfg_is_read = rd;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic burst(input logic [31:0] ea, input logic [8:0] el, input logic ew,
                         input string rq, output bit d);
        int t = 0;
        while (!bus_req && t < 50) begin
            @(negedge clk);
            t++;
        end
        chk(bus_req == 1'b1, rq, bus_req, 1);
        chk(bus_addr == ea, rq, bus_addr, ea);
        chk(bus_len == el, rq, bus_len, el);
        chk(bus_write == ew, rq, bus_write, ew);
        bus_ack = 1'b1;
        #1 d = done;
        @(negedge clk);
        bus_ack = 1'b0;
    endtask

    task automatic drain(input logic [8:0] n);
        buf_drain = n;
        @(negedge clk);
        buf_drain = '0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!bus_req && !pend && !busy && !done, "R1", {bus_req, pend, busy, done}, 0);
    endtask

    task automatic t_zero;
        wr_desc(32'h100, 16'd0, 12'd2, 32'h10, 1'b0);
        chk(done == 1'b1, "R12 zero bytes done", done, 1);
        chk(bus_req == 1'b0, "R12 zero bytes no req", bus_req, 0);
        @(negedge clk);
        chk(!done && !busy, "R12 idle after", {done, busy}, 0);
        wr_desc(32'h100, 16'd10, 12'd0, 32'h10, 1'b0);
        chk(done == 1'b1 && !bus_req, "R12 zero lines", {done, bus_req}, 2'b10);
        @(negedge clk);
    endtask

    task automatic t_write_window;
        wr_desc(32'h1000, 16'd100, 12'd3, 32'h200, 1'b0);
        chk(bus_req == 1'b1, "R2 immediate start", bus_req, 1);
        for (int n = 0; n < 3; n++) begin
            burst(32'h1000 + n * 32'h200, 9'd64, 1'b1, "R4 R6 line head", dn);
            chk(dn == 1'b0, "R9 no early done", dn, 0);
            burst(32'h1040 + n * 32'h200, 9'd36, 1'b1, "R5 short tail", dn);
            chk(dn == (n == 2), "R9 done on last", dn, (n == 2));
        end
        chk(!busy && !done, "R11 idle after window", {busy, done}, 0);
    endtask

    task automatic t_queue;
        wr_desc(32'h2000, 16'd64, 12'd2, 32'h100, 1'b0);
        wr_desc(32'h3000, 16'd64, 12'd1, 32'h0, 1'b0);
        chk(pend == 1'b1, "R3 pend set", pend, 1);
        wr_desc(32'h4000, 16'd64, 12'd1, 32'h0, 1'b0);
        chk(pend == 1'b1, "R3 pend held", pend, 1);
        burst(32'h2000, 9'd64, 1'b1, "R4 first line", dn);
        burst(32'h2100, 9'd64, 1'b1, "R4 second line", dn);
        chk(dn == 1'b1, "R9 done A", dn, 1);
        chk(pend == 1'b0, "R10 pend clears", pend, 0);
        chk(bus_req == 1'b1 && bus_addr == 32'h3000, "R10 back to back", bus_addr, 32'h3000);
        burst(32'h3000, 9'd64, 1'b1, "R10 queued burst", dn);
        chk(dn == 1'b1, "R9 done B", dn, 1);
        for (int i = 0; i < 5; i++) begin
            chk(!bus_req && !busy, "R11 R3 no reload, no discarded run", {bus_req, busy}, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_enable;
        chan_en = 1'b0;
        wr_desc(32'h5000, 16'd64, 12'd1, 32'h0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk(!bus_req && busy, "R13 held while disabled", {bus_req, busy}, 2'b01);
            @(negedge clk);
        end
        chan_en = 1'b1;
        #1 chk(bus_req == 1'b1, "R13 released", bus_req, 1);
        burst(32'h5000, 9'd64, 1'b1, "R13 burst", dn);
    endtask

    task automatic t_read_gate;
        rd_size = 2'd0;
        wr_desc(32'h8000, 16'd128, 12'd1, 32'h0, 1'b1);
        chk(bus_req == 1'b1, "R8 first read free", bus_req, 1);
        burst(32'h8000, 9'd64, 1'b0, "R7 code0 64", dn);
        chk(bus_req == 1'b0, "R8 gated after burst", bus_req, 0);
        drain(9'd32);
        chk(bus_req == 1'b0, "R8 half drained", bus_req, 0);
        drain(9'd32);
        chk(bus_req == 1'b1, "R8 full drained", bus_req, 1);
        burst(32'h8040, 9'd64, 1'b0, "R8 second read", dn);
        chk(dn == 1'b1, "R9 read done", dn, 1);
    endtask

    task automatic t_read_128;
        rd_size = 2'd1;
        wr_desc(32'h9000, 16'd300, 12'd2, 32'h1000, 1'b1);
        chk(bus_req == 1'b0, "R8 gate spans descriptors", bus_req, 0);
        for (int n = 0; n < 2; n++) begin
            drain(9'd128);
            burst(32'h9000 + n * 32'h1000, 9'd128, 1'b0, "R7 code1 128", dn);
            drain(9'd128);
            burst(32'h9080 + n * 32'h1000, 9'd128, 1'b0, "R7 code1 128", dn);
            drain(9'd128);
            burst(32'h9100 + n * 32'h1000, 9'd44, 1'b0, "R5 read tail", dn);
        end
        chk(dn == 1'b1, "R9 done 2-line read", dn, 1);
    endtask

    task automatic t_read_256;
        rd_size = 2'd3;
        wr_desc(32'hA000, 16'd256, 12'd1, 32'h0, 1'b1);
        drain(9'd255);
        chk(bus_req == 1'b0, "R8 one byte short", bus_req, 0);
        drain(9'd1);
        burst(32'hA000, 9'd256, 1'b0, "R7 code3 256", dn);
        rd_size = 2'd2;
        wr_desc(32'hB000, 16'd256, 12'd1, 32'h0, 1'b1);
        drain(9'd256);
        burst(32'hB000, 9'd256, 1'b0, "R7 code2 256", dn);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errs++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=0", cyc);
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero();
        t_write_window();
        t_queue();
        t_enable();
        t_read_gate();
        t_read_128();
        t_read_256();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule